// File: doc/BRIEF.md
# Second-Stage I/O Page Table Walker

This block turns an I/O virtual address into a physical address by walking a radix page table in memory. Each table is 4 KiB and holds 512 entries of 64 bits, so every level uses 9 address bits above a 12-bit page offset. A request carries the address and a read/write flag. Alongside it come a root table pointer, from which only bits 63:12 are used, and a 2-bit width code that sets the walk depth. The walker fetches one entry per level over a simple request/response memory port. It returns either a physical address with a page-size code, or a fault.

There is no present bit. An entry that is entirely zero is absent. Large pages (2 MiB or 1 GiB) may appear only at levels 1 and 2, where entry bit 7 marks them. When a permitted write reaches a leaf whose dirty bit is clear, the walker sets the dirty bit with a compare-and-swap on the memory port. If the entry changed after it was read, the walker evaluates the entry value the memory returns and carries on from it. Only one request is in flight at a time.

Top module: `iopt_walker`

## Requirements
- R1: After reset, req_ready is high, and rsp_valid and mem_req_valid are low.
- R2: For width code 1, 2 or 3, the walk starts at level code+1 (3-, 4- or 5-level walk) and issues exactly one entry read per level, down to and including the level where it stops.
- R3: Width code 0 is rejected with fault code 4 (bad-config), with no memory access, one cycle after acceptance.
- R4: The entry address for level L is the table base plus 8 times the 9-bit index taken from address bits [12+9L +: 9]. The top table base is root_ptr with bits 11:0 cleared; below the top, the base is entry bits 51:12 shifted left by 12.
- R5: An all-zero entry at any level ends the walk with fault code 1 (not-present).
- R6: At level 0 every non-zero entry is a leaf. At levels 1 and 2, an entry with bit 7 set is a leaf. At levels 3 and 4, bit 7 is ignored and the entry always points to the next table.
- R7: A leaf at level L gives rsp_pa equal to entry bits 51:12 shifted left by 12, with its low 12+9L bits replaced by the same bits of the request address, and rsp_size = L (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB). Entry bits 10 and 63:52 have no effect.
- R8: A leaf at level 1 or 2 whose output address has any non-zero bit in [12+9L-1:12] gives fault code 3 (misaligned). This check is made before the permission check.
- R9: A read needs leaf bit 0 and a write needs leaf bit 1. Without the needed bit, the walk ends with fault code 2 (permission).
- R10: A successful response carries leaf bit 11 on rsp_snoop.
- R11: A permitted write to a leaf with bit 9 clear issues one swap request with mem_req_cmp = entry and mem_req_wdata = entry with bit 9 set. A read, or a leaf with bit 9 already set, issues no swap. The memory returns the prior value and stores wdata only if the prior value equals cmp.
- R12: When a swap returns a value different from mem_req_cmp, the walker evaluates the returned value as the leaf and continues from it. It may swap again.
- R13: req_ready is low from acceptance until the response. rsp_valid is a one-cycle pulse. A fault response reports rsp_pa = 0, rsp_size = 0 and rsp_snoop = 0. Fault code 0 means success.
- R14: When memory answers one cycle after each request, the response comes 3·reads+1 cycles after acceptance. One swap adds 2 cycles. A failed swap followed by a successful swap adds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_addr | input | VA_W | I/O virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_ptr | input | 64 | Root table pointer, bits 63:12 used |
| width_code | input | 2 | Walk depth code (top level = code+1) |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_swap | output | 1 | 1 = compare-and-swap, 0 = read |
| mem_req_addr | output | 64 | Entry byte address |
| mem_req_cmp | output | 64 | Expected value for swap |
| mem_req_wdata | output | 64 | New value for swap |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Entry value (prior value for swap) |
| rsp_valid | output | 1 | Translation response pulse |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_size | output | 2 | Page size code |
| rsp_fault | output | 3 | 0 none, 1 not-present, 2 permission, 3 misaligned, 4 bad-config |
| rsp_snoop | output | 1 | Force-coherent flag of the leaf |

## Verification
A bad-config response is due on the first cycle after acceptance. Each level visited adds three cycles: one to issue the read, one for the memory reply, and one to evaluate the entry. The response then follows one cycle after the final evaluation, and each dirty-bit swap round trip adds its own fixed cycles. The bench drives a request, samples on every falling edge, and counts cycles until rsp_valid. It compares that count with 3·reads+1, plus the swap penalty worked out from the requirements, and samples all response fields in that same cycle. The count of memory reads and swaps is compared against the number of levels the walk should touch.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ABSENT = 3'd1,
      FLT_PERM   = 3'd2,
      FLT_ALIGN  = 3'd3,
      FLT_CFG    = 3'd4
   } iopt_fault_e;

   typedef enum logic [1:0] {
      KIND_ABSENT = 2'd0,
      KIND_TABLE  = 2'd1,
      KIND_LEAF   = 2'd2
   } iopt_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_EVAL  = 3'd3,
      ST_SWAP  = 3'd4,
      ST_SWAIT = 3'd5,
      ST_RESP  = 3'd6
   } iopt_state_e;

   localparam int unsigned BIT_RD    = 0;
   localparam int unsigned BIT_WR    = 1;
   localparam int unsigned BIT_LEAF  = 7;
   localparam int unsigned BIT_DIRTY = 9;
   localparam int unsigned BIT_SNOOP = 11;

endpackage

// File: rtl/iopt_addr_gen.sv
module iopt_addr_gen #(
   parameter int unsigned VA_W   = 57,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned OFS_W  = 12,
   parameter int unsigned LEVELS = 5,
   parameter int unsigned FRM_W  = 52,
   parameter int unsigned LVL_W  = 3
) (
   input  logic [FRM_W-1:0]         base_frame,
   input  logic [VA_W-1:0]          va,
   input  logic [LVL_W-1:0]         level,
   output logic [FRM_W+OFS_W-1:0]   ent_addr
);

   logic [IDX_W-1:0] idx_by_lvl [LEVELS];
   logic [IDX_W-1:0] idx;
   logic             unused_ofs;

   for (genvar l = 0; l < LEVELS; l++) begin : g_idx
      assign idx_by_lvl[l] = va[OFS_W+IDX_W*l +: IDX_W];
   end

   assign unused_ofs = ^va[OFS_W-1:0];

   always_comb begin
      idx = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (level == LVL_W'(l)) idx = idx_by_lvl[l];
      end
   end

   assign ent_addr = {base_frame, idx, 3'b000};

endmodule

// File: rtl/iopt_entry_decode.sv
module iopt_entry_decode
   import iopt_pkg::*;
#(
   parameter int unsigned VA_W        = 57,
   parameter int unsigned PA_W        = 52,
   parameter int unsigned IDX_W       = 9,
   parameter int unsigned OFS_W       = 12,
   parameter int unsigned LEAF_LEVELS = 3,
   parameter int unsigned LVL_W       = 3
) (
   input  logic [63:0]      entry,
   input  logic [LVL_W-1:0] level,
   input  logic [VA_W-1:0]  va,
   input  logic             is_write,
   output iopt_kind_e       kind,
   output logic             misaligned,
   output logic             perm_ok,
   output logic             needs_dirty,
   output logic             snoop,
   output logic [PA_W-1:0]  pa,
   output logic [1:0]       size
);

   localparam int unsigned TOP_SH = OFS_W + IDX_W*(LEAF_LEVELS-1);

   logic [PA_W-1:0] oa;
   logic [PA_W-1:0] pa_by  [LEAF_LEVELS];
   logic            mis_by [LEAF_LEVELS];
   logic            leaf_lvl;
   logic            unused_bits;

   assign oa       = {entry[PA_W-1:OFS_W], {OFS_W{1'b0}}};
   assign leaf_lvl = (level < LVL_W'(LEAF_LEVELS));

   for (genvar l = 0; l < LEAF_LEVELS; l++) begin : g_leaf
      localparam int unsigned SH = OFS_W + IDX_W*l;
      assign pa_by[l] = {oa[PA_W-1:SH], va[SH-1:0]};
      if (l == 0) begin : g_small
         assign mis_by[l] = 1'b0;
      end else begin : g_big
         assign mis_by[l] = |oa[SH-1:OFS_W];
      end
   end

   assign unused_bits = ^{entry[63:PA_W], entry[10], entry[8], entry[6:2],
                          va[VA_W-1:TOP_SH]};

   always_comb begin
      if (entry == 64'd0)                              kind = KIND_ABSENT;
      else if (level == '0)                            kind = KIND_LEAF;
      else if (leaf_lvl && entry[BIT_LEAF])            kind = KIND_LEAF;
      else                                             kind = KIND_TABLE;
   end

   always_comb begin
      pa         = '0;
      misaligned = 1'b0;
      for (int l = 0; l < LEAF_LEVELS; l++) begin
         if (level == LVL_W'(l)) begin
            pa         = pa_by[l];
            misaligned = mis_by[l];
         end
      end
   end

   assign size        = level[1:0];
   assign perm_ok     = is_write ? entry[BIT_WR] : entry[BIT_RD];
   assign needs_dirty = is_write && !entry[BIT_DIRTY];
   assign snoop       = entry[BIT_SNOOP];

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
   import iopt_pkg::*;
#(
   parameter int unsigned VA_W        = 57,
   parameter int unsigned PA_W        = 52,
   parameter int unsigned IDX_W       = 9,
   parameter int unsigned OFS_W       = 12,
   parameter int unsigned LEVELS      = 5,
   parameter int unsigned LEAF_LEVELS = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_addr,
   input  logic            req_write,
   input  logic [63:0]     root_ptr,
   input  logic [1:0]      width_code,
   output logic            mem_req_valid,
   output logic            mem_req_swap,
   output logic [63:0]     mem_req_addr,
   output logic [63:0]     mem_req_cmp,
   output logic [63:0]     mem_req_wdata,
   input  logic            mem_rsp_valid,
   input  logic [63:0]     mem_rsp_data,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_pa,
   output logic [1:0]      rsp_size,
   output logic [2:0]      rsp_fault,
   output logic            rsp_snoop
);

   localparam int unsigned ENT_W = 64;
   localparam int unsigned FRM_W = ENT_W - OFS_W;
   localparam int unsigned LVL_W = $clog2(LEVELS);

   if (VA_W != OFS_W + IDX_W*LEVELS) begin : g_bad_va
      $error("VA_W must equal OFS_W + IDX_W*LEVELS");
   end
   if (IDX_W + 3 != OFS_W) begin : g_bad_tbl
      $error("a table of 2**IDX_W 8-byte entries must fill one page");
   end
   if (PA_W > ENT_W || PA_W <= OFS_W + IDX_W*(LEAF_LEVELS-1)) begin : g_bad_pa
      $error("PA_W out of range");
   end
   if (LEAF_LEVELS > 4 || LEAF_LEVELS > LEVELS) begin : g_bad_leaf
      $error("LEAF_LEVELS out of range");
   end

   iopt_state_e      state_q;
   logic [VA_W-1:0]  va_q;
   logic             wr_q;
   logic [LVL_W-1:0] level_q;
   logic [FRM_W-1:0] base_q;
   logic [63:0]      entry_q;
   iopt_fault_e      fault_q;
   logic [PA_W-1:0]  pa_q;
   logic [1:0]       size_q;
   logic             snoop_q;

   iopt_kind_e       d_kind;
   logic             d_mis, d_perm, d_dirty, d_snoop;
   logic [PA_W-1:0]  d_pa;
   logic [1:0]       d_size;
   iopt_fault_e      eval_fault;
   logic             unused_root;

   assign unused_root = ^root_ptr[OFS_W-1:0];

   iopt_addr_gen #(
      .VA_W(VA_W), .IDX_W(IDX_W), .OFS_W(OFS_W),
      .LEVELS(LEVELS), .FRM_W(FRM_W), .LVL_W(LVL_W)
   ) u_addr (
      .base_frame (base_q),
      .va         (va_q),
      .level      (level_q),
      .ent_addr   (mem_req_addr)
   );

   iopt_entry_decode #(
      .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFS_W(OFS_W),
      .LEAF_LEVELS(LEAF_LEVELS), .LVL_W(LVL_W)
   ) u_dec (
      .entry       (entry_q),
      .level       (level_q),
      .va          (va_q),
      .is_write    (wr_q),
      .kind        (d_kind),
      .misaligned  (d_mis),
      .perm_ok     (d_perm),
      .needs_dirty (d_dirty),
      .snoop       (d_snoop),
      .pa          (d_pa),
      .size        (d_size)
   );

   always_comb begin
      eval_fault = FLT_NONE;
      if (d_kind == KIND_ABSENT)   eval_fault = FLT_ABSENT;
      else if (d_kind == KIND_LEAF) begin
         if (d_mis)                eval_fault = FLT_ALIGN;
         else if (!d_perm)         eval_fault = FLT_PERM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         level_q <= '0;
         base_q  <= '0;
         entry_q <= '0;
         fault_q <= FLT_NONE;
         pa_q    <= '0;
         size_q  <= '0;
         snoop_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q   <= req_addr;
               wr_q   <= req_write;
               base_q <= root_ptr[ENT_W-1:OFS_W];
               if (width_code == 2'd0) begin
                  fault_q <= FLT_CFG;
                  pa_q    <= '0;
                  size_q  <= '0;
                  snoop_q <= 1'b0;
                  state_q <= ST_RESP;
               end else begin
                  level_q <= LVL_W'(width_code) + LVL_W'(1);
                  state_q <= ST_READ;
               end
            end
            ST_READ:  state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               entry_q <= mem_rsp_data;
               state_q <= ST_EVAL;
            end
            ST_EVAL: begin
               if (d_kind == KIND_TABLE) begin
                  base_q  <= FRM_W'(entry_q[PA_W-1:OFS_W]);
                  level_q <= level_q - LVL_W'(1);
                  state_q <= ST_READ;
               end else if (eval_fault == FLT_NONE && d_dirty) begin
                  state_q <= ST_SWAP;
               end else begin
                  fault_q <= eval_fault;
                  pa_q    <= (eval_fault == FLT_NONE) ? d_pa : '0;
                  size_q  <= (eval_fault == FLT_NONE) ? d_size : 2'd0;
                  snoop_q <= (eval_fault == FLT_NONE) && d_snoop;
                  state_q <= ST_RESP;
               end
            end
            ST_SWAP:  state_q <= ST_SWAIT;
            ST_SWAIT: if (mem_rsp_valid) begin
               if (mem_rsp_data == entry_q) begin
                  fault_q <= FLT_NONE;
                  pa_q    <= d_pa;
                  size_q  <= d_size;
                  snoop_q <= d_snoop;
                  state_q <= ST_RESP;
               end else begin
                  entry_q <= mem_rsp_data;
                  state_q <= ST_EVAL;
               end
            end
            ST_RESP:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_READ) || (state_q == ST_SWAP);
   assign mem_req_swap  = (state_q == ST_SWAP);
   assign mem_req_cmp   = entry_q;
   assign mem_req_wdata = entry_q | (64'd1 << BIT_DIRTY);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_pa        = pa_q;
   assign rsp_size      = size_q;
   assign rsp_fault     = fault_q;
   assign rsp_snoop     = snoop_q;

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk
   import iopt_pkg::*;
#(
   parameter int unsigned VA_W = 57,
   parameter int unsigned PA_W = 52
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [1:0]      width_code,
   input logic            mem_req_valid,
   input logic            mem_req_swap,
   input logic [63:0]     mem_req_addr,
   input logic [63:0]     mem_req_cmp,
   input logic [63:0]     mem_req_wdata,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_pa,
   input logic [1:0]      rsp_size,
   input logic [2:0]      rsp_fault,
   input logic            rsp_snoop
);

   // R13
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R13
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R13
   fault_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'(FLT_NONE)) |-> (rsp_pa == '0 && rsp_size == 2'd0 && !rsp_snoop));

   // R7
   size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'(FLT_NONE)) |-> (rsp_size <= 2'd2));

   // R3
   bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && width_code == 2'd0) |=> (rsp_valid && rsp_fault == 3'(FLT_CFG)));

   // R2
   first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && width_code != 2'd0) |=> (mem_req_valid && !mem_req_swap));

   // R4
   entry_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

   // R13
   mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R11
   swap_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_swap) |-> (!mem_req_cmp[BIT_DIRTY] && mem_req_wdata[BIT_DIRTY]
                                           && mem_req_cmp[BIT_WR]));

   // R13
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

endmodule

bind iopt_walker iopt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_iopt_walker.sv
`timescale 1ns/1ps
module tb_iopt_walker;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [56:0]     req_addr = '0;
   logic            req_write = 1'b0;
   logic [63:0]     root_ptr = '0;
   logic [1:0]      width_code = 2'd0;
   logic            mem_req_valid;
   logic            mem_req_swap;
   logic [63:0]     mem_req_addr;
   logic [63:0]     mem_req_cmp;
   logic [63:0]     mem_req_wdata;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            rsp_valid;
   logic [51:0]     rsp_pa;
   logic [1:0]      rsp_size;
   logic [2:0]      rsp_fault;
   logic            rsp_snoop;

   always #2.5 clk = ~clk;

   iopt_walker dut (.*);

   // memory model: one-cycle response, compare-and-swap, optional interference
   logic [63:0] mem [logic [63:0]];
   logic        bw_en = 1'b0, bw_clr = 1'b0, spoil_mode = 1'b0;
   logic [63:0] bw_addr = '0, bw_data = '0, cur;
   int          nreq = 0, nswap = 0;

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (bw_clr) mem.delete();
      if (bw_en) mem[bw_addr] = bw_data;
      if (mem_req_valid) begin
         cur = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
         nreq = nreq + 1;
         if (mem_req_swap) begin
            nswap = nswap + 1;
            if (spoil_mode && !cur[8]) begin
               cur[8] = 1'b1;
               mem[mem_req_addr] = cur;
            end else if (cur == mem_req_cmp) begin
               mem[mem_req_addr] = mem_req_wdata;
            end
         end
         mem_rsp_data  <= cur;
         mem_rsp_valid <= 1'b1;
      end
   end

   int nvec = 0, nerr = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] tbl(input int l);
      return 64'h0000_0000_0040_0000 + (64'(l) << 12);
   endfunction

   function automatic logic [63:0] idx_off(input logic [63:0] va, input int l);
      return ((va >> (12 + 9*l)) & 64'h1FF) << 3;
   endfunction

   function automatic logic [63:0] peek(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   task automatic poke(input logic [63:0] a, input logic [63:0] d);
      bw_en = 1'b1; bw_addr = a; bw_data = d;
      @(negedge clk);
      bw_en = 1'b0;
   endtask

   task automatic mem_clear();
      bw_clr = 1'b1;
      @(negedge clk);
      bw_clr = 1'b0;
   endtask

   // one walk: build tables, issue, check every response field, latency and memory traffic
   task automatic do_walk(input int code, input int leaf, input int absent, input bit wr,
                          input logic [63:0] va_in, input logic [63:0] oa,
                          input logic [63:0] lbits, input bit spoil);
      int          top = code + 1;
      logic [63:0] va = va_in & ((64'd1 << 57) - 1);
      logic [63:0] mask = (64'd1 << (12 + 9*leaf)) - 1;
      logic [63:0] leaf_addr = tbl(leaf) + idx_off(va, leaf);
      logic [63:0] leaf_ent;
      logic [63:0] exp_pa, exp_mem;
      int          exp_fault, exp_reads, exp_swaps, exp_lat;
      int          r0, s0, cyc;
      bit          got, busy_bad, mis, perm;
      logic [51:0] a_pa;
      logic [1:0]  a_size;
      logic [2:0]  a_fault;
      logic        a_snoop;

      leaf_ent = (oa & 64'h000F_FFFF_FFFF_F000) | lbits | (leaf > 0 ? 64'h80 : 64'h0)
                 | 64'h8010_0000_0000_0400;
      mem_clear();
      if (code != 0) begin
         for (int l = top; l > leaf; l--) begin
            if (l != absent)
               poke(tbl(l) + idx_off(va, l),
                    tbl(l-1) | 64'h3 | (l >= 3 ? 64'h80 : 64'h0) | 64'h400);
            poke(tbl(l) + (idx_off(va, l) ^ 64'h8), 64'h0000_0000_0080_0083);
         end
         if (absent != leaf) poke(leaf_addr, leaf_ent);
      end

      mis  = (leaf > 0) && ((oa & mask & ~64'hFFF) != 0);
      perm = wr ? lbits[1] : lbits[0];
      if (code == 0)                              exp_fault = 4;
      else if (absent >= leaf && absent <= top)   exp_fault = 1;
      else if (mis)                               exp_fault = 3;
      else if (!perm)                             exp_fault = 2;
      else                                        exp_fault = 0;
      if (code == 0)          exp_reads = 0;
      else if (exp_fault == 1) exp_reads = top - absent + 1;
      else                    exp_reads = top - leaf + 1;
      exp_swaps = (exp_fault == 0 && wr && !lbits[9]) ? (spoil ? 2 : 1) : 0;
      if (code == 0) exp_lat = 1;
      else exp_lat = 3*exp_reads + 1 + (exp_swaps == 1 ? 2 : (exp_swaps == 2 ? 5 : 0));
      exp_pa = (exp_fault == 0) ? (((oa & ~mask) | (va & mask)) & 64'h000F_FFFF_FFFF_FFFF) : 64'd0;
      exp_mem = leaf_ent | (exp_swaps > 0 ? 64'h200 : 64'h0) | (exp_swaps == 2 ? 64'h100 : 64'h0);

      r0 = nreq; s0 = nswap; spoil_mode = spoil;
      req_valid = 1'b1; req_addr = va[56:0]; req_write = wr;
      root_ptr = tbl(top) | 64'hABC; width_code = code[1:0];
      cyc = 0; got = 0; busy_bad = 0;
      a_pa = '0; a_size = '0; a_fault = '0; a_snoop = 1'b0;
      while (!got && cyc < 300) begin
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
         if (req_ready) busy_bad = 1;
         if (rsp_valid) begin
            got = 1; a_pa = rsp_pa; a_size = rsp_size; a_fault = rsp_fault; a_snoop = rsp_snoop;
         end
      end
      @(negedge clk);
      chk("R13 one-cycle response pulse", 64'(rsp_valid), 64'd0);
      chk("R13 idle after response", 64'(req_ready), 64'd1);
      chk("R13 ready low while walking", 64'(busy_bad), 64'd0);
      chk("R14 response latency", 64'(cyc), 64'(exp_lat));
      chk("R2 entry reads per walk", 64'(nreq - r0 - (nswap - s0)), 64'(exp_reads));
      chk("R5/R8/R9/R3 fault code", 64'(a_fault), 64'(exp_fault));
      chk("R7 physical address", 64'(a_pa), exp_pa);
      chk("R7 size code", 64'(a_size), exp_fault == 0 ? 64'(leaf) : 64'd0);
      chk("R10 snoop flag", 64'(a_snoop), exp_fault == 0 ? 64'(lbits[11]) : 64'd0);
      chk("R11 swap count", 64'(nswap - s0), 64'(exp_swaps));
      if (exp_fault == 0 || exp_fault == 2)
         chk(spoil ? "R12 leaf after retried swap" : "R11 leaf after walk", peek(leaf_addr), exp_mem);
      spoil_mode = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nerr + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready after reset", 64'(req_ready), 64'd1);
      chk("R1 no response in reset", 64'(rsp_valid), 64'd0);
      chk("R1 no memory request in reset", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after release", 64'(req_ready), 64'd1);
      chk("R1 idle memory port", 64'(mem_req_valid), 64'd0);

      // R3: width code 0 rejected
      do_walk(0, 0, -1, 1'b0, 64'h0000_1234_5678_9000, 64'h0000_0000_0ABC_D000, 64'h3, 1'b0);
      // R5: absent entry at every level of a 5-level walk
      for (int a = 0; a <= 4; a++)
         do_walk(3, 0, a, 1'b0, 64'h01AB_CDEF_0123_4567 + 64'(a), 64'h0000_0123_4567_8000, 64'h3, 1'b0);
      // R8: misaligned large leaves, misalignment reported before permission
      do_walk(2, 1, -1, 1'b0, 64'h0000_7654_3210_FEDC, 64'h0000_0000_1234_5000, 64'h0, 1'b0);
      do_walk(2, 2, -1, 1'b1, 64'h0000_7654_3210_FEDC, 64'h0000_0000_4000_1000, 64'h3, 1'b0);
      // R12: interfering update makes the first swap fail
      do_walk(1, 0, -1, 1'b1, 64'h0000_0055_AA55_A123, 64'h0000_0000_0777_7000, 64'h003, 1'b1);
      do_walk(3, 2, -1, 1'b1, 64'h00F0_0F0F_F0F0_0FFF, 64'h0000_0003_C000_0000, 64'h803, 1'b1);

      // R2 R4 R6 R7 R9 R10 R11: sweep depth, leaf level, access, permissions, dirty
      begin
         int n = 0;
         for (int code = 1; code <= 3; code++)
            for (int leaf = 0; leaf <= 2; leaf++)
               for (int wr = 0; wr <= 1; wr++)
                  for (int pm = 0; pm <= 3; pm++)
                     for (int dt = 0; dt <= 1; dt++) begin
                        logic [63:0] va, oa, lb, msk;
                        msk = (64'd1 << (12 + 9*leaf)) - 1;
                        va  = (64'h0123_4567_89AB_CDEF * 64'(n + 7)) ^ (64'(n) << 30);
                        oa  = ((64'h0009_8765_4321_F000 * 64'(n + 3)) & 64'h000F_FFFF_FFFF_F000) & ~msk;
                        lb  = 64'(pm) | (64'(dt) << 9) | (64'(n & 1) << 11) | (64'((n >> 1) & 1) << 8);
                        do_walk(code, leaf, -1, wr[0], va, oa, lb, 1'b0);
                        n++;
                     end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule